// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down on a slow dedicated clock and asks for a system reset when software stops servicing it. Software controls it only through a small register port. A single key register takes magic values. One value starts the timer. One value reloads the down-counter and also re-locks the configuration. One value opens the divider and reload registers for writing. Any other value written to the key register locks them again.

The slow clock first passes through a programmable divider: codes 0..4 give 4, 8, 16, 32 and 64, and codes 5..7 are treated as 64. The divided tick then steps a 12-bit down-counter. When the counter runs out, the block drives a one-cycle reset request and then stays quiet until an external reset. A newly written divider code needs a few cycles to take effect, and a status bit reports that it is still pending. When the stop-on-debug control is set, a debug-halt input freezes all counting.

Top module: `iwdt_top`

## Requirements
- R1: After reset the timer is idle (`active` low, `rst_req` low), the divider register reads 0, the reload register reads 0xFFF, the status register reads 0 and the registers are locked.
- R2: A write to the divider register (address 1, bits [2:0]) or the reload register (address 2, bits [11:0]) changes it only when the unlock key 0x5555 was the last value written to the key register (address 0). Otherwise the write is ignored.
- R3: Writing any key value other than 0x5555, including 0xAAAA and 0xCCCC, locks the divider and reload registers again.
- R4: Writing 0xCCCC while idle loads the counter from the reload register and starts the timer. Exactly (reload+1)×divider counting cycles after that write, `rst_req` is high for one cycle.
- R5: Divider codes 0, 1, 2, 3 and 4 divide by 4, 8, 16, 32 and 64. Codes 5, 6 and 7 divide by 64.
- R6: Writing 0xAAAA while running reloads the counter from the reload register and so postpones expiry. The divider phase is not reset.
- R7: Status bit 0 (address 3) reads 1 for exactly 3 cycles after an accepted divider write. The new divider takes effect in the cycle that bit clears.
- R8: While `stop_on_dbg` and `dbg_halt` are both high, the divider and the counter hold their values. `dbg_halt` alone has no effect.
- R9: Once started, no register write stops the timer. After expiry `active` stays low, and a further 0xCCCC write does not restart the timer until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow dedicated watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divider, 2 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 key (reads 0), 1 divider, 2 reload, 3 status |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| stop_on_dbg | input | 1 | Enables freezing while debug-halted |
| dbg_halt | input | 1 | Processor halted in debug |
| active | output | 1 | Timer is counting |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench measures the time from start to the reset pulse for every divider code, including the aliased codes 5..7. A wrong decode or an off-by-one terminal count would fire early or late by whole divider periods. Writes made while locked, and writes made after a bogus key, are read back; a design that latched them would show the new value. Debug freeze is checked with the control set and with it clear. If the prescaler leaked through the freeze, or the halt input acted on its own, expiry would move by the wrong number of cycles. After expiry, further start keys are issued, and a design that restarted would show `active` again or pulse a second time.

// File: rtl/iwdt_pkg.sv
// Shared constants, register addresses and the divider decode for the
// key-protected watchdog. Assumes a 16-bit register data path.
package iwdt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int DIV_W  = 7;

    localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FEED   = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;

    localparam logic [ADDR_W-1:0] A_KEY    = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV    = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_DONE = 2'd2
    } wd_state_e;

    // Divider ratio for a 3-bit code; codes at or above 4 saturate at 64.
    function automatic logic [DIV_W-1:0] div_of_code(input logic [2:0] code);
        logic [DIV_W-1:0] r;
        if (code >= 3'd4) r = 7'd64;
        else              r = 7'd4 << code;
        return r;
    endfunction

endpackage

// File: rtl/iwdt_keyctl.sv
// Key decoder and lifecycle state. Turns key-register writes into start and
// feed pulses, tracks the configuration lock, and moves idle -> run -> done.
// Assumes expire is a single-cycle pulse from the counter.
module iwdt_keyctl
    import iwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    input  logic              expire,
    output logic              unlocked,
    output logic              start_p,
    output logic              feed_p,
    output wd_state_e         state
);

    // Decode the key only for actions legal in the current state.
    always_comb begin
        start_p = key_wr && (key_val == KEY_START) && (state == WD_IDLE);
        feed_p  = key_wr && (key_val == KEY_FEED)  && (state == WD_RUN);
    end

    // Lock flag: set by the unlock key, cleared by any other key value.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (key_wr) unlocked <= (key_val == KEY_UNLOCK);
    end

    // Lifecycle: start leaves idle, expiry ends running, done is terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
        end else begin
            unique case (state)
                WD_IDLE: if (start_p) state <= WD_RUN;
                WD_RUN:  if (expire)  state <= WD_DONE;
                default: state <= WD_DONE;
            endcase
        end
    end

endmodule

// File: rtl/iwdt_cfg.sv
// Divider and reload configuration registers with write protection. A
// divider write becomes active only after SYNC_CYCLES cycles, and busy is
// high meanwhile. The reload value is used as soon as it is written.
module iwdt_cfg
    import iwdt_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PR_W        = 3,
    parameter int SYNC_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              div_wr,
    input  logic              rl_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PR_W-1:0]   pr_q,
    output logic [CNT_W-1:0]  rl_q,
    output logic [DIV_W-1:0]  div_act,
    output logic              busy
);

    localparam int SW = $clog2(SYNC_CYCLES + 1);
    localparam logic [SW-1:0] SYNC_LOAD = SW'(SYNC_CYCLES);

    logic [SW-1:0] sync_q;
    logic          div_ok;
    logic          rl_ok;

    // Protected write enables.
    always_comb begin
        div_ok = div_wr && unlocked;
        rl_ok  = rl_wr  && unlocked;
        busy   = (sync_q != '0);
    end

    // Divider code register and its update-delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q    <= '0;
            sync_q  <= '0;
            div_act <= div_of_code(3'd0);
        end else if (div_ok) begin
            pr_q   <= wr_data[PR_W-1:0];
            sync_q <= SYNC_LOAD;
        end else if (sync_q != '0) begin
            sync_q <= sync_q - 1'b1;
            if (sync_q == SW'(1)) div_act <= div_of_code(pr_q);
        end
    end

    // Reload register, full scale after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     rl_q <= '1;
        else if (rl_ok) rl_q <= wr_data[CNT_W-1:0];
    end

endmodule

// File: rtl/iwdt_count.sv
// Prescaler and down-counter. Counts only while running and not frozen;
// start restarts the prescaler, feed reloads only the counter. The counter
// expires on a prescaler tick at zero and raises a one-cycle reset request.
module iwdt_count
    import iwdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             freeze,
    input  logic             start_p,
    input  logic             feed_p,
    input  logic [CNT_W-1:0] rl,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire,
    output logic             rst_req
);

    logic [DIV_W-1:0] pre_q;
    logic             cnt_en;
    logic             tick;

    // Tick when the prescaler reaches the last step of the active ratio.
    always_comb begin
        cnt_en = running && !freeze;
        tick   = cnt_en && (pre_q >= div - 7'd1);
        expire = tick && (cnt_q == '0) && !feed_p;
    end

    // Prescaler phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (start_p) pre_q <= '0;
        else if (tick)    pre_q <= '0;
        else if (cnt_en)  pre_q <= pre_q + 1'b1;
    end

    // Down-counter: load on start or feed, step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '1;
        else if (start_p || feed_p)    cnt_q <= rl;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Registered one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire;
    end

endmodule

// File: rtl/iwdt_top.sv
// Top of the key-protected watchdog: register decode, read mux and wiring of
// key control, configuration and counter. Single clock; the register port is
// assumed to be already in the watchdog clock domain.
module iwdt_top
    import iwdt_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PR_W        = 3,
    parameter int SYNC_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stop_on_dbg,
    input  logic              dbg_halt,
    output logic              active,
    output logic              rst_req
);

    logic             key_wr, div_wr, rl_wr;
    logic             unlocked, start_p, feed_p, expire, busy, freeze;
    wd_state_e        state;
    logic [PR_W-1:0]  pr_q;
    logic [CNT_W-1:0] rl_q, cnt_q;
    logic [DIV_W-1:0] div_act;

    // Write address decode and freeze condition.
    always_comb begin
        key_wr = wr_en && (wr_addr == A_KEY);
        div_wr = wr_en && (wr_addr == A_DIV);
        rl_wr  = wr_en && (wr_addr == A_RELOAD);
        freeze = stop_on_dbg && dbg_halt;
        active = (state == WD_RUN);
    end

    iwdt_keyctl u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(wr_data),
        .expire(expire), .unlocked(unlocked), .start_p(start_p),
        .feed_p(feed_p), .state(state)
    );

    iwdt_cfg #(.CNT_W(CNT_W), .PR_W(PR_W), .SYNC_CYCLES(SYNC_CYCLES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .div_wr(div_wr),
        .rl_wr(rl_wr), .wr_data(wr_data), .pr_q(pr_q), .rl_q(rl_q),
        .div_act(div_act), .busy(busy)
    );

    iwdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(active), .freeze(freeze),
        .start_p(start_p), .feed_p(feed_p), .rl(rl_q), .div(div_act),
        .cnt_q(cnt_q), .expire(expire), .rst_req(rst_req)
    );

    // Read mux; the key register reads as zero.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_DIV:    rd_data[PR_W-1:0]  = pr_q;
            A_RELOAD: rd_data[CNT_W-1:0] = rl_q;
            A_STAT:   rd_data[0]         = busy;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/iwdt_top_chk.sv
// Protocol checker for iwdt_top, attached by bind.
module iwdt_top_chk
    import iwdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              unlocked,
    input logic [PR_W-1:0]   pr_q,
    input logic [CNT_W-1:0]  rl_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              busy,
    input logic              freeze,
    input logic              feed_p,
    input logic              active,
    input logic              rst_req
);

    // R2
    locked_div_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIV && !unlocked) |=> $stable(pr_q));

    // R2
    locked_rl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RELOAD && !unlocked) |=> $stable(rl_q));

    // R7
    div_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIV && unlocked) |=> busy);

    // R4
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    req_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !active);

    // R9
    stop_only_by_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> rst_req);

    // R8
    freeze_holds_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && freeze && !feed_p) |=> $stable(cnt_q));

    // R6
    feed_loads_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_p |=> (cnt_q == $past(rl_q)));

endmodule

bind iwdt_top iwdt_top_chk #(.CNT_W(CNT_W), .PR_W(PR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .unlocked(unlocked), .pr_q(pr_q), .rl_q(rl_q), .cnt_q(cnt_q),
    .busy(busy), .freeze(freeze), .feed_p(feed_p), .active(active),
    .rst_req(rst_req)
);

// File: tb/tb_iwdt_top.sv
module tb_iwdt_top;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        stop_on_dbg = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        active, rst_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    iwdt_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_on_dbg(stop_on_dbg), .dbg_halt(dbg_halt),
        .active(active), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) rd_addr <= rd_addr + 2'd1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int divof(input int code);
        return (code >= 4) ? 64 : (4 << code);
    endfunction

    // Behavioural reference state
    int m_state, m_unl, m_pr, m_rl, m_sync, m_div, m_pre, m_cnt, m_req;
    int exp_rd;

    always @(posedge clk) begin
        bit kw, dw, rw, cen, st, fd, tk, ex;
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (rst_n) begin
            check(rst_req == (m_req != 0), "R4 rst_req", rst_req, m_req);
            check(active == (m_state == 1), "R9 active", active, m_state == 1);
            case (rd_addr)
                2'd1: exp_rd = m_pr;
                2'd2: exp_rd = m_rl;
                2'd3: exp_rd = (m_sync != 0) ? 1 : 0;
                default: exp_rd = 0;
            endcase
            check(rd_data == 16'(exp_rd), rd_addr == 3 ? "R7 status" : "R2 readback",
                  rd_data, exp_rd);
        end
        if (!rst_n) begin
            m_state = 0; m_unl = 0; m_pr = 0; m_rl = 'hFFF; m_sync = 0;
            m_div = 4; m_pre = 0; m_cnt = 'hFFF; m_req = 0;
        end else begin
            kw  = wr_en && wr_addr == 0;
            dw  = wr_en && wr_addr == 1 && m_unl != 0;
            rw  = wr_en && wr_addr == 2 && m_unl != 0;
            cen = (m_state == 1) && !(stop_on_dbg && dbg_halt);
            st  = kw && wr_data == 16'hCCCC && m_state == 0;
            fd  = kw && wr_data == 16'hAAAA && m_state == 1;
            tk  = cen && (m_pre >= m_div - 1);
            ex  = tk && m_cnt == 0 && !fd;
            m_req = ex;
            if (st) m_pre = 0;
            else if (tk) m_pre = 0;
            else if (cen) m_pre++;
            if (st || fd) m_cnt = m_rl;
            else if (tk && m_cnt != 0) m_cnt--;
            if (st) m_state = 1;
            else if (ex) m_state = 2;
            if (kw) m_unl = (wr_data == 16'h5555);
            if (dw) begin
                m_pr = wr_data & 7; m_sync = SYNC;
            end else if (m_sync != 0) begin
                if (m_sync == 1) m_div = divof(m_pr);
                m_sync--;
            end
            if (rw) m_rl = wr_data & 'hFFF;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; dbg_halt = 1'b0; stop_on_dbg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic config_wd(input int code, input int rl);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rl));
        wr(2'd0, 16'hAAAA);
        repeat (SYNC + 1) @(negedge clk);
    endtask

    // Start, then count cycles to the pulse; optional halt window.
    task automatic run_measure(input int hs, input int hl, output int n);
        wr(2'd0, 16'hCCCC);
        n = 0;
        while (n < 20000) begin
            dbg_halt = (n >= hs && n < hs + hl);
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
        dbg_halt = 1'b0;
    endtask

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(active == 0 && rst_req == 0, "R1 idle after reset", active, 0);
        repeat (4) @(negedge clk);

        // R2 locked write ignored
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd5);
        repeat (4) @(negedge clk);
        // R3 bogus key relocks
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd9);
        repeat (4) @(negedge clk);
        // R7 busy window on accepted write
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        repeat (6) @(negedge clk);

        // R4 / R5 timeouts for every code
        for (int c = 0; c < 8; c++) begin
            do_reset();
            config_wd(c, 3);
            run_measure(-1, 0, n);
            check(n == 4 * divof(c), c >= 5 ? "R5 aliased code" : "R4 R5 timeout", n, 4 * divof(c));
            repeat (3) @(negedge clk);
            check(!rst_req, "R4 single pulse", rst_req, 0);
        end

        // R8 freeze with control set adds halt length
        do_reset();
        config_wd(0, 7);
        stop_on_dbg = 1'b1;
        run_measure(5, 40, n);
        check(n == 32 + 40, "R8 freeze delays expiry", n, 72);
        // R8 halt alone has no effect
        do_reset();
        config_wd(0, 7);
        run_measure(5, 40, n);
        check(n == 32, "R8 halt alone ignored", n, 32);

        // R6 feed postpones; R9 keys cannot stop it
        do_reset();
        config_wd(0, 7);
        wr(2'd0, 16'hCCCC);
        repeat (20) @(negedge clk);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hAAAA);
        repeat (20) @(negedge clk);
        check(active, "R6 feed kept timer alive", active, 1);
        check(active, "R9 keys do not stop", active, 1);
        // mid-run divider change, checked by model
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        n = 0;
        while (!rst_req && n < 5000) begin @(negedge clk); n++; end
        check(rst_req, "R6 eventual expiry", rst_req, 1);
        // R9 restart after expiry refused
        repeat (2) @(negedge clk);
        wr(2'd0, 16'hCCCC);
        repeat (300) @(negedge clk);
        check(!active && !rst_req, "R9 no restart", active, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule